// File: doc/BRIEF.md
# Dual-Channel Serial DAC Loader

This block takes 16-bit audio samples, each tagged as left or right, and shifts them into an external stereo DAC. The DAC has a serial input and a latch input for each channel, and one serial clock that both channels share. Every sample goes out most-significant bit first on its channel's data line. The block then drives a short strobe on that channel's latch line. The falling edge of that strobe tells the DAC to commit the 16 bits it has most recently shifted in.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle after reset. Each channel has a single holding register. A sample that arrives while the channel is still shifting is parked there and goes out next. If a newer sample for the same channel arrives before the parked one has started, the newer one replaces it. A producer therefore never stalls, but it can lose a sample if it sends faster than one per frame.

The serial clock runs freely with a period of `2*HALF_DIV` system clocks. One frame takes 17 serial clock periods: 16 data periods and 1 latch period.

Top module: `dual_dac_loader`

## Requirements
- R1: `in_ready` is high in every cycle after the reset cycle. A sample is accepted in any cycle with `in_valid` high. `in_chan` = 0 selects the left channel and `in_chan` = 1 selects the right channel.
- R2: After reset, `dac_sclk` runs freely with a period of 2*HALF_DIV system clocks. In each period it is low for HALF_DIV cycles and then high for HALF_DIV cycles, so consecutive rising edges are exactly 2*HALF_DIV cycles apart.
- R3: Each sample goes out bit 15 first and bit 0 last. Each bit is held for one full serial clock period. A data line changes only while `dac_sclk` is low.
- R4: Left samples go out on `dac_dl` and are committed by `dac_ll`. Right samples go out on `dac_dr` and are committed by `dac_lr`. The two channels run independently.
- R5: In the serial period that follows the last data bit, the channel's latch line is high exactly while `dac_sclk` is low. The latch falls on the next rising edge of `dac_sclk`. The 16 bits sampled on the 16 rising edges before that edge equal the sample.
- R6: A latch line is never high while `dac_sclk` is high. A latch line falls exactly once per accepted sample that is transmitted, and never otherwise.
- R7: A sample that arrives while its channel is busy is sent immediately after the current latch period. A newer sample for the same channel replaces a held sample that has not yet started.
- R8: Synchronous active-high `rst` drives `dac_sclk`, both data lines and both latch lines low in the next cycle. It also drops any sample that is in flight or being held.
- R9: A data line is low while its channel has no sample to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on the input stream |
| in_ready | output | 1 | Block can take a sample (high after reset) |
| in_chan | input | 1 | Channel tag: 0 left, 1 right |
| in_sample | input | 16 | Signed audio sample |
| dac_sclk | output | 1 | Shared serial clock; the DAC shifts on its rising edge |
| dac_dl | output | 1 | Left serial data |
| dac_dr | output | 1 | Right serial data |
| dac_ll | output | 1 | Left latch; its falling edge commits the word |
| dac_lr | output | 1 | Right latch; its falling edge commits the word |

## Verification
A wrong bit counter or shift register appears as a wrong committed word at the very next falling edge of a latch line, about 17 serial periods after the sample is accepted. A wrong channel state machine can produce a latch edge with nothing queued, miss an edge that is owed, or drive a latch while the serial clock is high; each of these shows up within one serial period. A fault in the holding register shows up as a missing, repeated or stale word in the next frame. A fault in the divider shows up as a wrong spacing between serial clock edges.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
  localparam int SAMPLE_W = 16;
  localparam int NUM_CH   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } ser_state_t;

  localparam logic CH_LEFT  = 1'b0;
  localparam logic CH_RIGHT = 1'b1;
endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic slot_end,
  output logic low_next
);
  localparam int PHASES = 2 * HALF_DIV;
  localparam int CW     = (PHASES > 2) ? $clog2(PHASES) : 1;

  logic [CW-1:0] cnt, cnt_next;

  // slot_end marks the last system cycle of a serial period
  always_comb begin
    slot_end = (cnt == CW'(PHASES - 1));
    cnt_next = slot_end ? '0 : cnt + 1'b1;
    low_next = (cnt_next < CW'(HALF_DIV));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt  <= cnt_next;
      sclk <= ~low_next;
    end
  end

  // R2
  sclk_low_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
    slot_end |=> !sclk);
endmodule

// File: rtl/sample_hold.sv
module sample_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  // A write in the same cycle as a take keeps the new word held
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R7
  hold_newest_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (full && data == $past(wr_data)));
endmodule

// File: rtl/bit_serializer.sv
module bit_serializer
  import dacl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slot_end,
  input  logic         low_next,
  input  logic         sclk,
  input  logic         buf_full,
  input  logic [W-1:0] buf_data,
  output logic         take,
  output logic         sdata,
  output logic         latch
);
  localparam int BCW = $clog2(W);
  localparam logic [BCW-1:0] LAST = BCW'(W - 1);

  ser_state_t     state, state_next;
  logic [W-1:0]   shreg;
  logic [BCW-1:0] bitcnt;

  always_comb begin
    take       = slot_end && buf_full && (state != ST_SHIFT);
    state_next = state;
    if (slot_end) begin
      unique case (state)
        ST_SHIFT: if (bitcnt == LAST) state_next = ST_LATCH;
        default:  state_next = buf_full ? ST_SHIFT : ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      sdata  <= 1'b0;
      latch  <= 1'b0;
    end else begin
      state <= state_next;
      latch <= (state_next == ST_LATCH) && low_next;
      if (slot_end) begin
        unique case (state)
          ST_SHIFT: begin
            if (bitcnt != LAST) begin
              shreg  <= shreg << 1;
              sdata  <= shreg[W-2];
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: begin
            if (buf_full) begin
              shreg  <= buf_data;
              sdata  <= buf_data[W-1];
              bitcnt <= '0;
            end else begin
              sdata  <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  // R6
  latch_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    latch |-> !sclk);

  // R6
  latch_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
    latch |-> (state == ST_LATCH));

  // R3
  data_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));

  // R7
  held_start_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_end && buf_full && state != ST_SHIFT) |=> (state == ST_SHIFT && bitcnt == '0));
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacl_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_chan,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                dac_sclk,
  output logic                dac_dl,
  output logic                dac_dr,
  output logic                dac_ll,
  output logic                dac_lr
);
  logic slot_end, low_next;
  logic [NUM_CH-1:0] sdata, latch;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (dac_sclk),
    .slot_end (slot_end),
    .low_next (low_next)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic                wr_en, take, full;
    logic [SAMPLE_W-1:0] held;

    assign wr_en = in_valid && in_ready && (in_chan == 1'(ch));

    sample_hold #(.W(SAMPLE_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (in_sample),
      .take    (take),
      .full    (full),
      .data    (held)
    );

    bit_serializer #(.W(SAMPLE_W)) u_ser (
      .clk      (clk),
      .rst      (rst),
      .slot_end (slot_end),
      .low_next (low_next),
      .sclk     (dac_sclk),
      .buf_full (full),
      .buf_data (held),
      .take     (take),
      .sdata    (sdata[ch]),
      .latch    (latch[ch])
    );
  end

  assign dac_dl = sdata[CH_LEFT];
  assign dac_dr = sdata[CH_RIGHT];
  assign dac_ll = latch[CH_LEFT];
  assign dac_lr = latch[CH_RIGHT];

  // R8
  rst_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> !(dac_sclk || dac_dl || dac_dr || dac_ll || dac_lr || in_ready));
endmodule

// File: tb/test_dual_dac_loader.sv
module test_dual_dac_loader;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_chan = 1'b0;
  logic [15:0] in_sample = '0;
  logic in_ready, dac_sclk, dac_dl, dac_dr, dac_ll, dac_lr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] exp_l[$];
  logic [15:0] exp_r[$];

  always #4 clk = ~clk;

  dual_dac_loader #(.HALF_DIV(HALF_DIV)) i_dual_dac_loader (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_sample(in_sample), .dac_sclk(dac_sclk),
    .dac_dl(dac_dl), .dac_dr(dac_dr), .dac_ll(dac_ll), .dac_lr(dac_lr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one-cycle valid beat; optionally record the word as owed to the DAC
  task automatic send(input logic ch, input logic [15:0] val, input bit owed);
    @(negedge clk);
    in_valid  = 1'b1;
    in_chan   = ch;
    in_sample = val;
    if (owed) begin
      if (ch == 1'b0) exp_l.push_back(val);
      else            exp_r.push_back(val);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (24 * 2 * HALF_DIV) @(negedge clk);
  endtask

  // Monitor: a model DAC per channel, shifted on sclk rising edges
  logic [15:0] dac_sr_l = '0, dac_sr_r = '0;
  logic p_sclk = 0, p_dl = 0, p_dr = 0, p_ll = 0, p_lr = 0;
  int since_rise = -1;

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = 0; p_dl = 0; p_dr = 0; p_ll = 0; p_lr = 0;
      since_rise = -1;
    end else begin
      if (since_rise >= 0) since_rise++;
      // R6: latch only during low half of sclk
      if ((dac_ll || dac_lr) && dac_sclk)
        check(0, "R6 latch while sclk high", {dac_ll, dac_lr}, 0);
      // R3: data changes only while sclk low
      if (p_sclk && dac_sclk && (dac_dl != p_dl || dac_dr != p_dr))
        check(0, "R3 data moved while sclk high", {dac_dl, dac_dr}, {p_dl, p_dr});
      // R5/R4: commit on falling latch, word before this edge's shift
      if (p_ll && !dac_ll) begin
        if (exp_l.size() == 0) check(0, "R6 left latch with nothing owed", dac_sr_l, 0);
        else begin
          logic [15:0] e;
          e = exp_l.pop_front();
          check(dac_sr_l == e, "R5 R4 left word", dac_sr_l, e);
        end
      end
      if (p_lr && !dac_lr) begin
        if (exp_r.size() == 0) check(0, "R6 right latch with nothing owed", dac_sr_r, 0);
        else begin
          logic [15:0] e;
          e = exp_r.pop_front();
          check(dac_sr_r == e, "R5 R4 right word", dac_sr_r, e);
        end
      end
      if (!p_sclk && dac_sclk) begin
        dac_sr_l = {dac_sr_l[14:0], dac_dl};
        dac_sr_r = {dac_sr_r[14:0], dac_dr};
        // R2: rising edges 2*HALF_DIV cycles apart
        if (since_rise > 0 && since_rise != 2 * HALF_DIV)
          check(0, "R2 sclk period", since_rise, 2 * HALF_DIV);
        since_rise = 0;
      end
      p_sclk = dac_sclk; p_dl = dac_dl; p_dr = dac_dr; p_ll = dac_ll; p_lr = dac_lr;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 and R1: reset state
    check({dac_sclk, dac_dl, dac_dr, dac_ll, dac_lr} == 5'b0, "R8 outputs idle in reset",
          {dac_sclk, dac_dl, dac_dr, dac_ll, dac_lr}, 0);
    check(in_ready == 1'b0, "R1 ready low in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    repeat (4 * HALF_DIV) @(negedge clk);
    check(since_rise > 0, "R2 sclk running", since_rise, 1);

    // R3 R4: single words per channel
    send(1'b0, 16'hA5C3, 1);
    wait_idle();
    send(1'b1, 16'h8001, 1);
    wait_idle();
    // R4: both channels at once
    send(1'b0, 16'h1234, 1);
    send(1'b1, 16'hFEDC, 1);
    wait_idle();
    // R7: back-to-back on left, second held and sent next
    send(1'b0, 16'h0F0F, 1);
    repeat (10) @(negedge clk);
    send(1'b0, 16'hF0F0, 1);
    wait_idle(); wait_idle();
    // R7: overwrite of an unstarted held word
    send(1'b1, 16'h3C3C, 1);
    repeat (10) @(negedge clk);
    send(1'b1, 16'h5555, 0);
    repeat (2) @(negedge clk);
    send(1'b1, 16'hAAAA, 1);
    wait_idle(); wait_idle();
    // R5 boundary words
    send(1'b1, 16'h0000, 1); wait_idle();
    send(1'b1, 16'hFFFF, 1); wait_idle();
    send(1'b0, 16'h8000, 1); wait_idle();
    send(1'b0, 16'h0001, 1); wait_idle();
    // R9 and R6: idle lines once the channels are drained
    check({dac_dl, dac_dr} == 2'b00, "R9 data idle low", {dac_dl, dac_dr}, 0);
    check({dac_ll, dac_lr} == 2'b00, "R6 latch idle low", {dac_ll, dac_lr}, 0);
    // R8: reset mid-word drops it; no latch edge owed
    send(1'b0, 16'h7E7E, 0);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({dac_sclk, dac_dl, dac_dr, dac_ll, dac_lr} == 5'b0, "R8 outputs idle after mid reset",
          {dac_sclk, dac_dl, dac_dr, dac_ll, dac_lr}, 0);
    rst = 1'b0;
    wait_idle();
    send(1'b0, 16'hC001, 1);
    wait_idle();
    // R6: every owed word was committed exactly once
    check(exp_l.size() == 0, "R6 left words outstanding", exp_l.size(), 0);
    check(exp_r.size() == 0, "R6 right words outstanding", exp_r.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule